// File: doc/BRIEF.md
# Burst Host Bus Slave for a Block Cipher

This block sits between a host processor and a 128-bit block cipher. The host reaches it over a 32-bit bus that carries an address and then data. Each bus item is marked by a one-cycle request strobe. The host opens a burst with an address. A write burst then brings exactly four 32-bit words, which the block gathers into one 128-bit value and commits to the register that the address selects. A read burst returns a 128-bit register as four words, least significant word first. The block marks each returned word with a one-cycle acknowledge pulse.

There are three 128-bit targets: the data block, the key and a control word. When a data block is committed, the block starts the cipher and raises busy. Busy stays high until the cipher reports completion, and at that point the block latches the cipher output as the result. While busy is high, the block ignores any attempt to open a burst. A read of the data address returns the latest cipher result. The shared bus is split into an input, an output and an output enable. The output enable is high only in the cycles where a read word is valid.

Top module: `host_burst_slave`

## Requirements
- R1: After reset, busy, acknowledge, output enable and cipher start are low. The bus output is zero, and the data, key, control and result registers are all zero.
- R2: A burst opens on a clock edge where request and burst are high and busy is low. A low read-not-write line makes it a write burst. After that, each edge with request and burst high takes one word. The first word fills bits [31:0] of the 128-bit value and the later words fill the bits above it in order.
- R3: The edge that takes the fourth word commits the gathered 128 bits to the target selected by address bits [5:4]: 0 is data, 1 is key, 2 is control (control bit 0 drives the cipher mode output), and 3 discards the value.
- R4: A commit to the data target gives a cipher start pulse exactly one cycle long. Busy rises in the same cycle as that pulse.
- R5: While busy is high, a cipher-done input seen at an edge latches the cipher output into the result register and drops busy in the next cycle.
- R6: A burst-open attempt sampled while busy is high is ignored. No register changes and no acknowledge is given.
- R7: A read burst opens like a write burst but with read-not-write high. While request stays high, the words go out least significant first. Each word has a one-cycle acknowledge pulse, and a low cycle separates consecutive pulses. The first pulse is visible after the second rising edge, counting the opening edge as the first.
- R8: A read of address select 0 returns the result register, 1 the key, 2 the control word, and 3 returns all zeros.
- R9: The output enable is high exactly in the cycles where acknowledge is high. At all other times the bus output is zero.
- R10: If burst drops before the fourth word, the partial write is discarded, the target keeps its old value, and the block returns to idle. The next write burst starts again from bits [31:0].
- R11: If request drops during a read burst, acknowledges stop from the next cycle and the block returns to idle.
- R12: Once four words have been taken, further request strobes in the same write burst are ignored until burst drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_burst | input | 1 | Burst flag from host |
| bus_rnw | input | 1 | Read-not-write, sampled at burst open |
| bus_req | input | 1 | Request strobe, one per bus item on writes, held on reads |
| bus_ad_in | input | 32 | Address/data from host |
| bus_ad_out | output | 32 | Read data to host, zero when not enabled |
| bus_ad_oe | output | 1 | Output enable for the shared bus |
| bus_ack | output | 1 | Acknowledge pulse per read word |
| bus_busy | output | 1 | Cipher operation in progress |
| cph_data | output | 128 | Data block to cipher |
| cph_key | output | 128 | Key to cipher |
| cph_mode | output | 1 | Control bit 0 (cipher direction) |
| cph_start | output | 1 | One-cycle cipher start |
| cph_done | input | 1 | Cipher completion strobe |
| cph_result | input | 128 | Cipher output block |

## Verification
Two functions can meet in one cycle: the cipher-done strobe releasing busy, and a host burst-open attempt. Busy is registered, so the block samples the attempt against the old, still-high busy and must ignore it. The bench drives both in the same cycle and releases the request one cycle later. Its reference model then expects busy to fall but no acknowledge and no register change. The bench also drops burst and request on the last word cycle of a burst and in the middle of a read, and checks that the block returns to idle with no commit.

// File: rtl/hbs_pkg.sv
// Shared types for the burst host bus slave.
package hbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WR      = 3'd1,
        ST_WR_HOLD = 3'd2,
        ST_RD      = 3'd3,
        ST_RD_HOLD = 3'd4
    } hbs_state_e;

    typedef enum logic [1:0] {
        TGT_DATA = 2'd0,
        TGT_KEY  = 2'd1,
        TGT_CTRL = 2'd2,
        TGT_NONE = 2'd3
    } hbs_tgt_e;
endpackage

// File: rtl/hbs_ctrl.sv
// Burst sequencer. It opens write and read bursts, counts words and paces read
// words with one idle cycle between them.
// Assumes: request strobes are sampled only with the burst flag high; busy is registered.
module hbs_ctrl
    import hbs_pkg::*;
#(
    parameter int DW      = 32,
    parameter int WORDS   = 4,
    parameter int SEL_LSB = 4,
    localparam int IW     = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int CW     = $clog2(WORDS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_i,
    input  logic          rnw_i,
    input  logic          req_i,
    input  logic [DW-1:0] ad_i,
    input  logic          busy_i,
    output hbs_tgt_e      tgt_o,
    output logic          take_o,
    output logic          last_o,
    output logic [IW-1:0] idx_o,
    output logic          fire_o
);
    hbs_state_e     state_q;
    logic [CW-1:0]  cnt_q;
    logic           gap_q;
    hbs_tgt_e       tgt_q;
    logic           open_w;

    // Burst open: request with burst flag while the cipher is idle.
    assign open_w = (state_q == ST_IDLE) && req_i && burst_i && !busy_i;

    // Word capture and read fire strobes.
    always_comb begin
        take_o = (state_q == ST_WR) && burst_i && req_i;
        last_o = take_o && (cnt_q == CW'(WORDS - 1));
        fire_o = (state_q == ST_RD) && req_i && !gap_q && (cnt_q < CW'(WORDS));
        idx_o  = cnt_q[IW-1:0];
        tgt_o  = tgt_q;
    end

    // Target select captured from the address item.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgt_q <= TGT_DATA;
        else if (open_w)
            tgt_q <= hbs_tgt_e'(ad_i[SEL_LSB +: 2]);
    end

    // Burst state machine with word counter and read pacing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            gap_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (open_w) begin
                        cnt_q   <= '0;
                        gap_q   <= 1'b0;
                        state_q <= rnw_i ? ST_RD : ST_WR;
                    end
                end
                ST_WR: begin
                    if (!burst_i) begin
                        state_q <= ST_IDLE;
                    end else if (req_i) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(WORDS - 1))
                            state_q <= ST_WR_HOLD;
                    end
                end
                ST_WR_HOLD: begin
                    if (!burst_i)
                        state_q <= ST_IDLE;
                end
                ST_RD: begin
                    if (!req_i) begin
                        state_q <= ST_IDLE;
                    end else if (!gap_q) begin
                        cnt_q <= cnt_q + 1'b1;
                        gap_q <= 1'b1;
                    end else begin
                        gap_q <= 1'b0;
                        if (cnt_q == CW'(WORDS))
                            state_q <= ST_RD_HOLD;
                    end
                end
                ST_RD_HOLD: begin
                    if (!req_i)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hbs_wr_stage.sv
// Write staging. It holds the first WORDS-1 words of a write burst. The final
// word bypasses staging so the full block is ready on the commit edge.
// Assumes: a new burst rewrites slots from index 0 before the next commit.
module hbs_wr_stage #(
    parameter int DW    = 32,
    parameter int WORDS = 4,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BW   = DW * WORDS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [IW-1:0] idx_i,
    input  logic [DW-1:0] ad_i,
    output logic [BW-1:0] block_o
);
    genvar g;
    generate
        for (g = 0; g < WORDS - 1; g++) begin : g_slot
            logic [DW-1:0] word_q;
            // Capture this slot when its index is strobed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (take_i && (idx_i == IW'(g)))
                    word_q <= ad_i;
            end
            assign block_o[g*DW +: DW] = word_q;
        end
    endgenerate

    assign block_o[(WORDS-1)*DW +: DW] = ad_i;
endmodule

// File: rtl/hbs_regs.sv
// Target registers, busy flag and result capture.
// Assumes: commits happen only while busy is low.
module hbs_regs
    import hbs_pkg::*;
#(
    parameter int BW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_i,
    input  hbs_tgt_e      tgt_i,
    input  logic [BW-1:0] block_i,
    input  logic          done_i,
    input  logic [BW-1:0] result_i,
    output logic [BW-1:0] data_o,
    output logic [BW-1:0] key_o,
    output logic [BW-1:0] ctrl_o,
    output logic [BW-1:0] res_o,
    output logic          busy_o,
    output logic          start_o
);
    logic start_w;
    assign start_w = commit_i && (tgt_i == TGT_DATA);

    // Commit the gathered block into the selected target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            key_o  <= '0;
            ctrl_o <= '0;
        end else if (commit_i) begin
            case (tgt_i)
                TGT_DATA: data_o <= block_i;
                TGT_KEY:  key_o  <= block_i;
                TGT_CTRL: ctrl_o <= block_i;
                default:  ;
            endcase
        end
    end

    // Start pulse and busy flag around one cipher operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            start_o <= 1'b0;
        end else begin
            start_o <= start_w;
            if (start_w)
                busy_o <= 1'b1;
            else if (busy_o && done_i)
                busy_o <= 1'b0;
        end
    end

    // Result capture on cipher completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_o <= '0;
        else if (busy_o && done_i)
            res_o <= result_i;
    end
endmodule

// File: rtl/hbs_rd_port.sv
// Read serializer. It selects the target block and word and registers the
// acknowledge, output enable and bus data.
// Assumes: target registers are stable during a read burst.
module hbs_rd_port
    import hbs_pkg::*;
#(
    parameter int DW    = 32,
    parameter int WORDS = 4,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BW   = DW * WORDS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic [IW-1:0] idx_i,
    input  hbs_tgt_e      tgt_i,
    input  logic [BW-1:0] res_i,
    input  logic [BW-1:0] key_i,
    input  logic [BW-1:0] ctrl_i,
    output logic          ack_o,
    output logic          oe_o,
    output logic [DW-1:0] ad_o
);
    logic [BW-1:0] blk_w;
    logic [DW-1:0] word_w;

    // Block select by target.
    always_comb begin
        case (tgt_i)
            TGT_DATA: blk_w = res_i;
            TGT_KEY:  blk_w = key_i;
            TGT_CTRL: blk_w = ctrl_i;
            default:  blk_w = '0;
        endcase
        word_w = blk_w[idx_i*DW +: DW];
    end

    // Registered bus drive, gated to zero outside data phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
            oe_o  <= 1'b0;
            ad_o  <= '0;
        end else begin
            ack_o <= fire_i;
            oe_o  <= fire_i;
            ad_o  <= fire_i ? word_w : '0;
        end
    end
endmodule

// File: rtl/host_burst_slave.sv
// Burst host bus slave top. It joins the sequencer, write staging, target
// registers and read serializer.
// Assumes: the bus is split into input, output and output enable at this level.
module host_burst_slave
    import hbs_pkg::*;
#(
    parameter int DW      = 32,
    parameter int WORDS   = 4,
    parameter int SEL_LSB = 4,
    localparam int BW     = DW * WORDS,
    localparam int IW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_burst,
    input  logic          bus_rnw,
    input  logic          bus_req,
    input  logic [DW-1:0] bus_ad_in,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    output logic          bus_ack,
    output logic          bus_busy,
    output logic [BW-1:0] cph_data,
    output logic [BW-1:0] cph_key,
    output logic          cph_mode,
    output logic          cph_start,
    input  logic          cph_done,
    input  logic [BW-1:0] cph_result
);
    hbs_tgt_e      tgt_w;
    logic          take_w, last_w, fire_w;
    logic [IW-1:0] idx_w;
    logic [BW-1:0] block_w, ctrl_w, res_w;

    hbs_ctrl #(.DW(DW), .WORDS(WORDS), .SEL_LSB(SEL_LSB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .burst_i(bus_burst), .rnw_i(bus_rnw),
        .req_i(bus_req), .ad_i(bus_ad_in), .busy_i(bus_busy),
        .tgt_o(tgt_w), .take_o(take_w), .last_o(last_w), .idx_o(idx_w),
        .fire_o(fire_w)
    );

    hbs_wr_stage #(.DW(DW), .WORDS(WORDS)) u_stage (
        .clk(clk), .rst_n(rst_n), .take_i(take_w), .idx_i(idx_w),
        .ad_i(bus_ad_in), .block_o(block_w)
    );

    hbs_regs #(.BW(BW)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit_i(last_w), .tgt_i(tgt_w),
        .block_i(block_w), .done_i(cph_done), .result_i(cph_result),
        .data_o(cph_data), .key_o(cph_key), .ctrl_o(ctrl_w), .res_o(res_w),
        .busy_o(bus_busy), .start_o(cph_start)
    );

    hbs_rd_port #(.DW(DW), .WORDS(WORDS)) u_rd (
        .clk(clk), .rst_n(rst_n), .fire_i(fire_w), .idx_i(idx_w),
        .tgt_i(tgt_w), .res_i(res_w), .key_i(cph_key), .ctrl_i(ctrl_w),
        .ack_o(bus_ack), .oe_o(bus_ad_oe), .ad_o(bus_ad_out)
    );

    assign cph_mode = ctrl_w[0];
endmodule

// File: rtl/hbs_checker.sv
// Temporal checks on the burst host bus slave ports, bound to the top.
module hbs_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_ack,
    input logic          bus_ad_oe,
    input logic [DW-1:0] bus_ad_out,
    input logic          bus_busy,
    input logic          cph_start,
    input logic          cph_done
);
    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_oe_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ad_oe == bus_ack);

    assert_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ad_oe |-> (bus_ad_out == '0));

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cph_start |=> !cph_start);

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cph_start |-> bus_busy);

    assert_busy_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && cph_done && !cph_start) |=> !bus_busy);

    assert_no_read_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> !bus_busy);

    assert_read_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ack);
endmodule

bind host_burst_slave hbs_checker #(.DW(DW)) i_hbs_checker (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_ad_oe(bus_ad_oe), .bus_ad_out(bus_ad_out), .bus_busy(bus_busy),
    .cph_start(cph_start), .cph_done(cph_done)
);

// File: tb/test_host_burst_slave.sv
`timescale 1ns/1ps
module test_host_burst_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst = 1'b0, rnw = 1'b0, req = 1'b0, done = 1'b0;
    logic [31:0]  ad_in = '0;
    logic [127:0] res_in = '0;
    logic [31:0]  ad_out;
    logic         oe, ack, busy, start, mode;
    logic [127:0] data, key;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    host_burst_slave i_host_burst_slave (
        .clk(clk), .rst_n(rst_n), .bus_burst(burst), .bus_rnw(rnw),
        .bus_req(req), .bus_ad_in(ad_in), .bus_ad_out(ad_out),
        .bus_ad_oe(oe), .bus_ack(ack), .bus_busy(busy), .cph_data(data),
        .cph_key(key), .cph_mode(mode), .cph_start(start), .cph_done(done),
        .cph_result(res_in)
    );

    task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    int st = 0, tgt = 0;
    logic [31:0] wq[$];
    logic [31:0] rq[$];
    logic gap = 0;
    logic [127:0] m_data = '0, m_key = '0, m_ctrl = '0, m_res = '0;
    logic m_busy = 0, m_start = 0, m_ack = 0;
    logic [31:0] m_out = '0;
    always @(posedge clk) begin
        logic [127:0] b;
        logic fire;
        fire = 0;
        if (!rst_n) begin
            st = 0; wq.delete(); rq.delete(); gap = 0;
            m_data = '0; m_key = '0; m_ctrl = '0; m_res = '0;
            m_busy = 0; m_start = 0; m_ack = 0; m_out = '0;
        end else begin
            m_start = 0;
            m_out = '0;
            case (st)
                0: if (req && burst && !m_busy) begin
                    tgt = int'(ad_in[5:4]);
                    wq.delete(); rq.delete(); gap = 0;
                    if (rnw) begin
                        b = (tgt == 0) ? m_res : (tgt == 1) ? m_key : (tgt == 2) ? m_ctrl : '0;
                        for (int i = 0; i < 4; i++) rq.push_back(b[32*i +: 32]);
                        st = 3;
                    end else st = 1;
                end
                1: if (!burst) st = 0;
                   else if (req) begin
                       wq.push_back(ad_in);
                       if (wq.size() == 4) begin
                           b = {wq[3], wq[2], wq[1], wq[0]};
                           if (tgt == 0) begin m_data = b; m_start = 1; end
                           else if (tgt == 1) m_key = b;
                           else if (tgt == 2) m_ctrl = b;
                           st = 2;
                       end
                   end
                2: if (!burst) st = 0;
                3: if (!req) st = 0;
                   else if (!gap) begin fire = 1; m_out = rq.pop_front(); gap = 1; end
                   else begin gap = 0; if (rq.size() == 0) st = 4; end
                4: if (!req) st = 0;
                default: st = 0;
            endcase
            m_ack = fire;
            if (m_busy && done) begin m_busy = 0; m_res = res_in; end
            if (m_start) m_busy = 1;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) if (rst_n) begin
        chk("R7 ack", ack, m_ack);
        chk("R9 oe", oe, m_ack);
        chk("R9 bus_out", ad_out, m_out);
        chk("R5 busy", busy, m_busy);
        chk("R4 start", start, m_start);
        chk("R3 data", data, m_data);
        chk("R3 key", key, m_key);
        chk("R3 mode", mode, m_ctrl[0]);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_burst(input logic [31:0] addr, input logic [127:0] blk, input int n, input bit extra);
        @(negedge clk); burst = 1; rnw = 0; req = 0;
        @(negedge clk); req = 1; ad_in = addr;
        for (int i = 0; i < n; i++) begin @(negedge clk); ad_in = blk[32*i +: 32]; end
        if (extra) begin @(negedge clk); ad_in = 32'hdead_beef; end
        @(negedge clk); req = 0; burst = (n == 4);
        @(negedge clk); burst = 0;
    endtask

    task automatic rd_burst(input logic [31:0] addr, input int stop_after, output logic [127:0] blk, output int got);
        blk = '0; got = 0;
        @(negedge clk); burst = 1; rnw = 1; req = 1; ad_in = addr;
        for (int t = 0; t < 20 && got < stop_after; t++) begin
            @(negedge clk);
            if (ack) begin blk[32*got +: 32] = ad_out; got++; end
        end
        req = 0; burst = 0; rnw = 0;
        @(negedge clk);
    endtask

    initial begin
        logic [127:0] blk;
        int got, acks;
        cyc(3);
        chk("R1 busy", busy, 0); chk("R1 ack", ack, 0); chk("R1 oe", oe, 0);
        chk("R1 start", start, 0); chk("R1 out", ad_out, 0); chk("R1 data", data, 0);
        chk("R1 key", key, 0); chk("R1 mode", mode, 0);
        rst_n = 1;
        cyc(2);
        // R2 R3 R4: data write, word order low first, start and busy
        wr_burst(32'h0000_0000, 128'h44444444_33333333_22222222_11111111, 4, 0);
        chk("R2 data order", data, 128'h44444444_33333333_22222222_11111111);
        chk("R4 busy raised", busy, 1);
        // R6: opens while busy are ignored
        wr_burst(32'h0000_0010, 128'h1, 4, 0);
        chk("R6 key unchanged", key, 0);
        rd_burst(32'h0000_0010, 4, blk, got);
        chk("R6 no read ack", got, 0);
        // Collision: done and read open in the same cycle
        @(negedge clk); done = 1; res_in = 128'hcafe0004_cafe0003_cafe0002_cafe0001;
        burst = 1; rnw = 1; req = 1; ad_in = 32'h0;
        @(negedge clk); done = 0; req = 0; burst = 0; rnw = 0;
        chk("R5 busy released", busy, 0);
        acks = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (ack) acks++; end
        chk("R6 collision dropped", acks, 0);
        // R7 R8: result readback
        rd_burst(32'h0000_0000, 4, blk, got);
        chk("R8 result read", blk, 128'hcafe0004_cafe0003_cafe0002_cafe0001);
        chk("R7 four acks", got, 4);
        // R3 R8: key and control
        wr_burst(32'h0000_0010, 128'hbbbb0004_bbbb0003_bbbb0002_bbbb0001, 4, 0);
        rd_burst(32'h0000_0010, 4, blk, got);
        chk("R8 key read", blk, 128'hbbbb0004_bbbb0003_bbbb0002_bbbb0001);
        wr_burst(32'h0000_0020, 128'h0000_0000_0000_0000_0000_0000_0000_0001, 4, 0);
        chk("R3 mode set", mode, 1);
        rd_burst(32'h0000_0020, 4, blk, got);
        chk("R8 ctrl read", blk, 128'h1);
        // R3 R8: unmapped select
        wr_burst(32'h0000_0030, 128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff, 4, 0);
        chk("R3 unmapped key", key, 128'hbbbb0004_bbbb0003_bbbb0002_bbbb0001);
        chk("R3 unmapped busy", busy, 0);
        rd_burst(32'h0000_0030, 4, blk, got);
        chk("R8 unmapped zero", blk, 0);
        // R10: aborted key write, then clean write
        wr_burst(32'h0000_0010, 128'h0_0_77777777_66666666, 2, 0);
        chk("R10 abort keeps key", key, 128'hbbbb0004_bbbb0003_bbbb0002_bbbb0001);
        wr_burst(32'h0000_0010, 128'h9d000004_9d000003_9d000002_9d000001, 4, 0);
        chk("R10 restart from low word", key, 128'h9d000004_9d000003_9d000002_9d000001);
        // R12: extra strobe after four words
        wr_burst(32'h0000_0010, 128'h5a000004_5a000003_5a000002_5a000001, 4, 1);
        chk("R12 extra ignored", key, 128'h5a000004_5a000003_5a000002_5a000001);
        // R11: read dropped after two words
        rd_burst(32'h0000_0010, 2, blk, got);
        acks = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (ack) acks++; end
        chk("R11 stop after drop", acks, 0);
        chk("R11 partial words", blk[63:0], 64'h5a000002_5a000001);
        cyc(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule